// File: doc/BRIEF.md
# Indirect Register Access Bridge

The bridge gives a byte-wide host port access to a bank of wide internal configuration registers that the host cannot address directly. The host writes a value into a small window of byte registers: four bytes of write data, a two-byte write target, a two-byte read target and a command byte. It then writes the command byte. The bridge runs one transaction on a request/acknowledge register bus, and a busy bit stays visible to the host for as long as that transaction lasts. When a read finishes, the fetched word sits in four read-back bytes of the same window.

Only one transaction can be outstanding. While it runs, the staged operands are frozen. Any host write aimed at the staging or command bytes is dropped and sets a sticky reject flag, which the host can inspect and clear later. The bus address, write data and direction are taken directly from the frozen staging registers, so they hold steady until the acknowledge arrives. The busy bit drops one cycle after the acknowledge.

Top module: `idx_bridge`

## Requirements
- R1: After reset, every window byte reads 0, including the command byte, and rb_req is low.
- R2: With the default parameters the host byte map is as follows. Offsets 0..3 hold write-data bytes, least significant first. Offsets 4/5 hold the write target (low/high) and 6/7 the read target (low/high). Offset 8 is the command byte. Offsets 9..12 hold read-back bytes, least significant first. Every staging byte reads back the value last written while idle.
- R3: In the command byte, bit 0 is busy, bit 1 is direction (1 = read) and bit 2 is the reject flag. Writing it while idle with bit 1 = 0 and bit 0 = 1 starts a write. From the next cycle rb_req = 1, rb_we = 1, rb_addr = {offset 5, offset 4}, rb_wdata = {offsets 3,2,1,0}, and busy reads 1. The register bank receives that word at that address.
- R4: Writing the command byte while idle with bit 1 = 1 starts a read, whatever bit 0 holds. From the next cycle rb_req = 1, rb_we = 0 and rb_addr = {offset 7, offset 6}.
- R5: A command write while idle with bits 1 and 0 both 0 starts nothing. Busy stays 0 and rb_req stays low.
- R6: rb_req, rb_we, rb_addr and rb_wdata stay constant until the cycle in which rb_ack is high. In the cycle after that, rb_req and busy are 0. Busy is therefore high for exactly one cycle more than the acknowledge latency.
- R7: The word on rb_rdata in the acknowledge cycle of a read is stored in offsets 9..12. It keeps its value through later write transactions and idle periods until the next read completes.
- R8: While busy, host writes to offsets 0..8 leave those bytes unchanged, start no transaction and set the reject flag. The flag stays set after busy clears. An idle command write with bit 2 = 1 clears it.
- R9: A host write that arrives in the acknowledge cycle itself is still treated as a write while busy. It is dropped and sets the reject flag.
- R10: An rb_ack pulse while idle has no effect: read-back bytes and busy are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hb_wr | input | 1 | Host byte write strobe |
| hb_addr | input | 4 | Host window offset |
| hb_wdata | input | 8 | Host write byte |
| hb_rdata | output | 8 | Host read byte for hb_addr (combinational) |
| rb_req | output | 1 | Register bus request, held until acknowledged |
| rb_we | output | 1 | Register bus direction, 1 = write |
| rb_addr | output | 16 | Register bus address |
| rb_wdata | output | 32 | Register bus write word |
| rb_ack | input | 1 | Register bus acknowledge, one cycle |
| rb_rdata | input | 32 | Register bus read word, valid with rb_ack |

## Verification
A host write and the bus acknowledge can land in the same cycle. At that moment the busy bit is about to clear but has not cleared yet. The bench provokes this by watching for the acknowledge from a register-bank model with a fixed latency and driving a write to the write-target low byte in that very cycle. It then judges the result one cycle later: busy must read 0, the target byte must still hold its old value, and the reject flag must be set. A second overlap is also exercised: an acknowledge that arrives while idle, which must leave the read-back bytes alone.

// File: rtl/idxb_pkg.sv
package idxb_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } seq_st_t;

  // Bit positions inside the command/status byte
  localparam int CMD_BUSY_BIT = 0;
  localparam int CMD_DIR_BIT  = 1;
  localparam int CMD_REJ_BIT  = 2;

endpackage

// File: rtl/idxb_seq.sv
module idxb_seq
  import idxb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic dir_rd,
  input  logic rb_ack,
  output logic busy,
  output logic cap_rd
);

  seq_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (launch) st_d = ST_WAIT;
      ST_WAIT: if (rb_ack) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign busy   = (st_q == ST_WAIT);
  assign cap_rd = busy && rb_ack && dir_rd;

  AST_NO_SPURIOUS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !launch) |=> !busy); // R5

  AST_BUSY_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rb_ack) |=> busy); // R6

endmodule

// File: rtl/idxb_regs.sv
module idxb_regs
  import idxb_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int HAW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hb_wr,
  input  logic [HAW-1:0] hb_addr,
  input  logic [7:0]    hb_wdata,
  input  logic          busy,
  input  logic          cap_rd,
  input  logic [DW-1:0] rb_rdata,
  output logic [DW-1:0] wd_flat,
  output logic [AW-1:0] wa_flat,
  output logic [AW-1:0] ra_flat,
  output logic [DW-1:0] rd_flat,
  output logic          dir_q,
  output logic          rej_q,
  output logic          launch
);

  localparam int NB       = DW / 8;
  localparam int NAB      = AW / 8;
  localparam int WA_BASE  = NB;
  localparam int RA_BASE  = NB + NAB;
  localparam int CMD_ADDR = NB + 2 * NAB;
  localparam int RD_BASE  = CMD_ADDR + 1;

  logic wr_idle;
  logic cmd_wr;
  logic reject;
  logic dir_d;
  logic rej_d;

  assign wr_idle = hb_wr && !busy;
  assign cmd_wr  = wr_idle && (hb_addr == HAW'(CMD_ADDR));
  assign reject  = hb_wr && busy && (hb_addr < HAW'(RD_BASE));
  assign launch  = cmd_wr && (hb_wdata[CMD_DIR_BIT] || hb_wdata[CMD_BUSY_BIT]);

  // Write-data staging bytes
  for (genvar i = 0; i < NB; i++) begin : g_wd
    logic       en;
    logic [7:0] q;
    assign en = wr_idle && (hb_addr == HAW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= hb_wdata;
    end
    assign wd_flat[8*i +: 8] = q;
  end

  // Write and read target bytes
  for (genvar j = 0; j < NAB; j++) begin : g_ab
    logic       en_w, en_r;
    logic [7:0] qw, qr;
    assign en_w = wr_idle && (hb_addr == HAW'(WA_BASE + j));
    assign en_r = wr_idle && (hb_addr == HAW'(RA_BASE + j));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    qw <= '0;
      else if (en_w) qw <= hb_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    qr <= '0;
      else if (en_r) qr <= hb_wdata;
    end
    assign wa_flat[8*j +: 8] = qw;
    assign ra_flat[8*j +: 8] = qr;
  end

  // Read-back word
  logic [DW-1:0] rd_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (cap_rd) rd_q <= rb_rdata;
  end
  assign rd_flat = rd_q;

  // Direction and reject flag
  always_comb begin
    dir_d = dir_q;
    if (cmd_wr) dir_d = hb_wdata[CMD_DIR_BIT];
  end

  always_comb begin
    rej_d = rej_q;
    if (reject)                            rej_d = 1'b1;
    else if (cmd_wr && hb_wdata[CMD_REJ_BIT]) rej_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      dir_q <= dir_d;
      rej_q <= rej_d;
    end
  end

  AST_STAGE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(wd_flat) && $stable(wa_flat) && $stable(ra_flat) && $stable(dir_q))); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_rd |=> $stable(rd_flat)); // R7

  AST_REJ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rej_q)) |-> $past(busy)); // R8

endmodule

// File: rtl/idxb_rmux.sv
module idxb_rmux
  import idxb_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int HAW = 4
) (
  input  logic [HAW-1:0] hb_addr,
  input  logic [DW-1:0]  wd_flat,
  input  logic [AW-1:0]  wa_flat,
  input  logic [AW-1:0]  ra_flat,
  input  logic [DW-1:0]  rd_flat,
  input  logic           busy,
  input  logic           dir_q,
  input  logic           rej_q,
  output logic [7:0]     hb_rdata
);

  localparam int NB       = DW / 8;
  localparam int NAB      = AW / 8;
  localparam int WA_BASE  = NB;
  localparam int RA_BASE  = NB + NAB;
  localparam int CMD_ADDR = NB + 2 * NAB;
  localparam int RD_BASE  = CMD_ADDR + 1;

  logic [7:0] stat_b;

  always_comb begin
    stat_b = '0;
    stat_b[CMD_BUSY_BIT] = busy;
    stat_b[CMD_DIR_BIT]  = dir_q;
    stat_b[CMD_REJ_BIT]  = rej_q;
  end

  always_comb begin
    hb_rdata = '0;
    for (int i = 0; i < NB; i++) begin
      if (hb_addr == HAW'(i))           hb_rdata = wd_flat[8*i +: 8];
      if (hb_addr == HAW'(RD_BASE + i)) hb_rdata = rd_flat[8*i +: 8];
    end
    for (int j = 0; j < NAB; j++) begin
      if (hb_addr == HAW'(WA_BASE + j)) hb_rdata = wa_flat[8*j +: 8];
      if (hb_addr == HAW'(RA_BASE + j)) hb_rdata = ra_flat[8*j +: 8];
    end
    if (hb_addr == HAW'(CMD_ADDR)) hb_rdata = stat_b;
  end

endmodule

// File: rtl/idx_bridge.sv
module idx_bridge
  import idxb_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int HAW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hb_wr,
  input  logic [HAW-1:0] hb_addr,
  input  logic [7:0]     hb_wdata,
  output logic [7:0]     hb_rdata,
  output logic           rb_req,
  output logic           rb_we,
  output logic [AW-1:0]  rb_addr,
  output logic [DW-1:0]  rb_wdata,
  input  logic           rb_ack,
  input  logic [DW-1:0]  rb_rdata
);

  // Reset release synchronizer
  logic [1:0] rst_sync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  logic [DW-1:0] wd_flat;
  logic [DW-1:0] rd_flat;
  logic [AW-1:0] wa_flat;
  logic [AW-1:0] ra_flat;
  logic          dir_q;
  logic          rej_q;
  logic          launch;
  logic          busy;
  logic          cap_rd;

  idxb_regs #(.AW(AW), .DW(DW), .HAW(HAW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_ns),
    .hb_wr    (hb_wr),
    .hb_addr  (hb_addr),
    .hb_wdata (hb_wdata),
    .busy     (busy),
    .cap_rd   (cap_rd),
    .rb_rdata (rb_rdata),
    .wd_flat  (wd_flat),
    .wa_flat  (wa_flat),
    .ra_flat  (ra_flat),
    .rd_flat  (rd_flat),
    .dir_q    (dir_q),
    .rej_q    (rej_q),
    .launch   (launch)
  );

  idxb_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_ns),
    .launch (launch),
    .dir_rd (dir_q),
    .rb_ack (rb_ack),
    .busy   (busy),
    .cap_rd (cap_rd)
  );

  idxb_rmux #(.AW(AW), .DW(DW), .HAW(HAW)) u_rmux (
    .hb_addr  (hb_addr),
    .wd_flat  (wd_flat),
    .wa_flat  (wa_flat),
    .ra_flat  (ra_flat),
    .rd_flat  (rd_flat),
    .busy     (busy),
    .dir_q    (dir_q),
    .rej_q    (rej_q),
    .hb_rdata (hb_rdata)
  );

  assign rb_req   = busy;
  assign rb_we    = busy && !dir_q;
  assign rb_addr  = dir_q ? ra_flat : wa_flat;
  assign rb_wdata = wd_flat;

  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_ns)
    (rb_req && !rb_ack) |=> ($stable(rb_addr) && $stable(rb_wdata) && $stable(rb_we) && rb_req)); // R6

  AST_ACK_ENDS_REQ: assert property (@(posedge clk) disable iff (!rst_ns)
    (rb_req && rb_ack) |=> !rb_req); // R6

  AST_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_ns)
    (!rb_req && rb_ack) |=> $stable(rd_flat)); // R10

endmodule

// File: tb/test_idx_bridge.sv
module test_idx_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hb_wr = 1'b0;
  logic [3:0]  hb_addr = '0;
  logic [7:0]  hb_wdata = '0;
  logic [7:0]  hb_rdata;
  logic        rb_req, rb_we;
  logic [15:0] rb_addr;
  logic [31:0] rb_wdata;
  logic        rb_ack = 1'b0;
  logic [31:0] rb_rdata = '0;

  int total = 0;
  int bad   = 0;
  int lat   = 1;
  int cnt   = 0;
  logic stray = 1'b0;
  logic [31:0] mem [0:15];

  always #4 clk = ~clk;

  idx_bridge i_idx_bridge (
    .clk(clk), .rst_n(rst_n), .hb_wr(hb_wr), .hb_addr(hb_addr),
    .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .rb_req(rb_req), .rb_we(rb_we),
    .rb_addr(rb_addr), .rb_wdata(rb_wdata), .rb_ack(rb_ack), .rb_rdata(rb_rdata)
  );

  // Register bank model with programmable acknowledge latency
  always @(posedge clk) begin
    if (rb_ack) begin
      rb_ack <= 1'b0;
    end else if (stray) begin
      rb_ack   <= 1'b1;
      rb_rdata <= 32'hDEAD_BEEF;
    end else if (rb_req) begin
      if (cnt == lat - 1) begin
        rb_ack   <= 1'b1;
        rb_rdata <= mem[rb_addr[3:0]];
        if (rb_we) mem[rb_addr[3:0]] <= rb_wdata;
        cnt <= 0;
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    hb_wr = 1'b1; hb_addr = a; hb_wdata = d;
    @(negedge clk);
    hb_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [3:0] a, output logic [7:0] v);
    hb_addr = a;
    #1;
    v = hb_rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [7:0] s;
    n = 0;
    host_rd(4'd8, s);
    while (s[0] && n < 100) begin
      n++;
      @(negedge clk);
      host_rd(4'd8, s);
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 13; a++) begin
      host_rd(4'(a), v);
      chk($sformatf("R1 reset byte %0d", a), {24'h0, v}, 32'h0);
    end
    chk("R1 reset req", {31'h0, rb_req}, 32'h0);
  endtask

  task automatic t_stage();
    logic [7:0] v;
    host_wr(4'd0, 8'h11); host_wr(4'd1, 8'h22);
    host_wr(4'd2, 8'h33); host_wr(4'd3, 8'h44);
    host_wr(4'd4, 8'h05); host_wr(4'd5, 8'h00);
    host_wr(4'd6, 8'h03); host_wr(4'd7, 8'h00);
    host_rd(4'd2, v); chk("R2 wdata byte2", {24'h0, v}, 32'h33);
    host_rd(4'd4, v); chk("R2 waddr low", {24'h0, v}, 32'h05);
    host_rd(4'd6, v); chk("R2 raddr low", {24'h0, v}, 32'h03);
    chk("R2 no request from staging", {31'h0, rb_req}, 32'h0);
  endtask

  task automatic t_write();
    logic [7:0] s;
    int n;
    logic stable_ok;
    lat = 4;
    host_wr(4'd8, 8'h01);
    host_rd(4'd8, s);
    chk("R3 busy after launch", {31'h0, s[0]}, 32'h1);
    chk("R3 req", {31'h0, rb_req}, 32'h1);
    chk("R3 we", {31'h0, rb_we}, 32'h1);
    chk("R3 addr", {16'h0, rb_addr}, 32'h0005);
    chk("R3 wdata", rb_wdata, 32'h4433_2211);
    n = 0; stable_ok = 1'b1;
    while (s[0] && n < 100) begin
      if (rb_addr !== 16'h0005 || rb_wdata !== 32'h4433_2211 || rb_req !== 1'b1) stable_ok = 1'b0;
      n++;
      @(negedge clk);
      host_rd(4'd8, s);
    end
    chk("R6 bus held while waiting", {31'h0, stable_ok}, 32'h1);
    chk("R6 busy cycles = latency+1", n, lat + 1);
    chk("R6 req low after ack", {31'h0, rb_req}, 32'h0);
    chk("R3 bank received word", mem[5], 32'h4433_2211);
  endtask

  task automatic t_read();
    logic [7:0] v;
    int n;
    lat = 2;
    mem[3] = 32'hCAFE_F00D;
    host_wr(4'd8, 8'h02);
    chk("R4 req", {31'h0, rb_req}, 32'h1);
    chk("R4 we low", {31'h0, rb_we}, 32'h0);
    chk("R4 addr", {16'h0, rb_addr}, 32'h0003);
    wait_idle(n);
    chk("R6 read busy cycles", n, lat + 1);
    host_rd(4'd9,  v); chk("R7 rdata byte0", {24'h0, v}, 32'h0D);
    host_rd(4'd10, v); chk("R7 rdata byte1", {24'h0, v}, 32'hF0);
    host_rd(4'd11, v); chk("R7 rdata byte2", {24'h0, v}, 32'hFE);
    host_rd(4'd12, v); chk("R7 rdata byte3", {24'h0, v}, 32'hCA);
  endtask

  task automatic t_nolaunch();
    logic [7:0] s;
    host_wr(4'd8, 8'h00);
    host_rd(4'd8, s);
    chk("R5 busy stays 0", {31'h0, s[0]}, 32'h0);
    chk("R5 req stays 0", {31'h0, rb_req}, 32'h0);
    @(negedge clk);
    chk("R5 req still 0", {31'h0, rb_req}, 32'h0);
  endtask

  task automatic t_reject();
    logic [7:0] v;
    int n;
    lat = 8;
    host_wr(4'd0, 8'h55);
    host_wr(4'd8, 8'h01);
    host_wr(4'd0, 8'hAA);
    host_wr(4'd4, 8'h07);
    host_wr(4'd8, 8'h02);
    host_rd(4'd0, v); chk("R8 wdata byte0 unchanged", {24'h0, v}, 32'h55);
    host_rd(4'd4, v); chk("R8 waddr low unchanged", {24'h0, v}, 32'h05);
    host_rd(4'd8, v); chk("R8 reject flag while busy", {29'h0, v[2:0]}, 32'h5);
    chk("R8 bus addr unchanged", {16'h0, rb_addr}, 32'h0005);
    wait_idle(n);
    host_rd(4'd8, v); chk("R8 reject flag stays, idle", {29'h0, v[2:0]}, 32'h4);
    @(negedge clk);
    chk("R8 no second transaction", {31'h0, rb_req}, 32'h0);
    chk("R8 bank got original word", mem[5], 32'h4433_2255);
    host_rd(4'd12, v); chk("R7 rdata kept over write", {24'h0, v}, 32'hCA);
    host_wr(4'd8, 8'h04);
    host_rd(4'd8, v); chk("R8 reject flag cleared", {29'h0, v[2:0]}, 32'h0);
    chk("R8 clear starts nothing", {31'h0, rb_req}, 32'h0);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    int g;
    lat = 3;
    host_wr(4'd8, 8'h01);
    g = 0;
    while (!rb_ack && g < 50) begin
      @(negedge clk);
      g++;
    end
    hb_wr = 1'b1; hb_addr = 4'd4; hb_wdata = 8'h09;
    @(negedge clk);
    hb_wr = 1'b0;
    host_rd(4'd8, v); chk("R9 idle after ack", {31'h0, v[0]}, 32'h0);
    chk("R9 reject flag set", {31'h0, v[2]}, 32'h1);
    host_rd(4'd4, v); chk("R9 waddr low unchanged", {24'h0, v}, 32'h05);
    host_wr(4'd8, 8'h04);
  endtask

  task automatic t_stray();
    logic [7:0] v;
    @(negedge clk);
    stray = 1'b1;
    @(negedge clk);
    stray = 1'b0;
    @(negedge clk);
    host_rd(4'd9, v);  chk("R10 rdata byte0 kept", {24'h0, v}, 32'h0D);
    host_rd(4'd12, v); chk("R10 rdata byte3 kept", {24'h0, v}, 32'hCA);
    host_rd(4'd8, v);  chk("R10 busy stays 0", {31'h0, v[0]}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_stage();
    t_write();
    t_read();
    t_nolaunch();
    t_reject();
    t_collide();
    t_stray();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule